// File: doc/BRIEF.md
# Wake-Up Source Power Mode Controller

This block is the power-mode front end of a small microcontroller. A CPU reaches it through one 8-bit register. A single-cycle write strobe with a data byte sends writes, and a combinational read bus returns the register value. Software writes the register to ask for a low-power Sleep or Suspend state. The same write picks which events may end that state. After the wake, software reads the register to find out which event or events occurred.

Five wake sources enter the block. Two are asynchronous levels: the reset pin, which wakes on a falling edge, and the analog comparator, which wakes on a rising edge. Each of these passes through a synchronizer and an edge detector. The other three are single-cycle pulses that are already synchronous to the clock: RTC oscillator failure, RTC alarm and port match. Every event sets a sticky flag, whether or not its source is enabled. The block blocks a mode request while any flag is pending. After a wake from Suspend it hides the flags for a short settling window. The oscillators, the clock gating and the comparator itself are outside the block. The block only drives the request levels and the wake pulse.

Top module: `pmu_wake_ctrl`

## Requirements
- R1: A read returns zeros in bits 7..5. Bits 4..0 return the wake flags, in this order: bit 4 reset-pin fall, bit 3 oscillator fail, bit 2 alarm, bit 1 port match, bit 0 comparator rise.
- R2: A write in the active state, with no flag pending, acts as follows. Bit 7 = 1 raises `sleep_req_o` after the next clock edge. Bit 6 = 1 raises `suspend_req_o`. If both bits are 1, Sleep is taken and Suspend is not. The two requests are never high together.
- R3: A write with bit 5 = 1 clears all five flags at that clock edge.
- R4: Each event sets its own flag at the edge where it is seen, whether or not its source is enabled. The flag stays set until it is cleared.
- R5: A Sleep or Suspend request written while any flag reads 1 is ignored, and the block stays active.
- R6: Every write loads the four source enables from bits 3..0 and replaces all earlier enables. A mode request therefore arms only the enables written in its own byte.
- R7: In Sleep or Suspend, the block wakes when an enabled source has an event or a pending flag, or when the reset pin falls. On wake it drops the request and pulses `wake_o` high for exactly one cycle. An event on a disabled source sets its flag but does not wake the block.
- R8: After a wake from Suspend, bits 4..0 read 0 for MASK_CYCLES (default 2) clocks, and then show the latched flags. After a wake from Sleep the flags show at once.
- R9: The comparator input passes through a SYNC_STAGES-flop synchronizer. Its flag sets on the third clock edge after a rising level change when SYNC_STAGES is 2. A falling change sets no flag. The reset-pin input is treated the same way, but on its falling edge.
- R10: An event in the same cycle as a write with bit 5 = 1 leaves its flag set.
- R11: After reset the block is active with both requests and `wake_o` low, and with all enables at 0. The flags take the value of the RST_FLAGS parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Register read value |
| rst_pin_i | input | 1 | Reset-pin level, asynchronous, idle high |
| osc_fail_i | input | 1 | RTC oscillator-fail pulse, synchronous |
| alarm_i | input | 1 | RTC alarm pulse, synchronous |
| port_match_i | input | 1 | Port-match pulse, synchronous |
| cmp_i | input | 1 | Comparator output level, asynchronous |
| sleep_req_o | output | 1 | Sleep mode request level |
| suspend_req_o | output | 1 | Suspend mode request level |
| wake_o | output | 1 | One-cycle wake indication |

## Verification
The bench builds two copies of the block. The first keeps RST_FLAGS at zero. A reference model tracks it on every clock through flag setting, clearing, enable replacement, Sleep and Suspend wakes, and the two-cycle read mask. The second copy uses RST_FLAGS = 5'b10010, so it comes out of reset with flags pending. That case shows the blocked-entry rule straight from reset and the CLEAR that releases it. SYNC_STAGES and MASK_CYCLES keep their defaults of 2, which sets the exact edge counts checked for comparator and reset-pin latency and for the masked read window.

// File: rtl/pmu_wake_pkg.sv
package pmu_wake_pkg;

   localparam int REG_W       = 8;
   localparam int NUM_SRC     = 5;
   localparam int NUM_EN      = 4;

   localparam int BIT_SLEEP   = 7;
   localparam int BIT_SUSPEND = 6;
   localparam int BIT_CLEAR   = 5;

   localparam int SRC_RSTPIN  = 4;
   localparam int SRC_OSCFAIL = 3;
   localparam int SRC_ALARM   = 2;
   localparam int SRC_PMATCH  = 1;
   localparam int SRC_CMP     = 0;

   typedef enum logic [1:0] {
      PM_ACTIVE  = 2'd0,
      PM_SLEEP   = 2'd1,
      PM_SUSPEND = 2'd2
   } pm_state_e;

endpackage

// File: rtl/pmu_sync_edge.sv
module pmu_sync_edge #(
   parameter int STAGES  = 2,
   parameter bit FALLING = 1'b0,
   parameter bit IDLE    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic edge_o
);

   logic [STAGES-1:0] shift_q;
   logic              prev_q;
   logic              sync_lvl;

   assign sync_lvl = shift_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= {STAGES{IDLE}};
         prev_q  <= IDLE;
      end else begin
         shift_q <= {shift_q[STAGES-2:0], async_i};
         prev_q  <= sync_lvl;
      end
   end

   generate
      if (FALLING) begin : g_fall
         assign edge_o = prev_q & ~sync_lvl;
      end else begin : g_rise
         assign edge_o = ~prev_q & sync_lvl;
      end
   endgenerate

endmodule

// File: rtl/pmu_wake_flags.sv
module pmu_wake_flags #(
   parameter int               NSRC      = 5,
   parameter logic [NSRC-1:0]  RST_FLAGS = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   input  logic [NSRC-1:0] event_i,
   output logic [NSRC-1:0] flags_o
);

   logic [NSRC-1:0] flags_q;
   logic [NSRC-1:0] flags_d;

   // set dominates clear, bit by bit
   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_bit
         always_comb begin
            if (event_i[i])
               flags_d[i] = 1'b1;
            else if (clear_i)
               flags_d[i] = 1'b0;
            else
               flags_d[i] = flags_q[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags_q <= RST_FLAGS;
      else
         flags_q <= flags_d;
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/pmu_mode_ctrl.sv
module pmu_mode_ctrl
   import pmu_wake_pkg::*;
#(
   parameter int MASK_CYCLES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [REG_W-1:0]   wdata_i,
   input  logic [NUM_SRC-1:0] flags_i,
   input  logic [NUM_SRC-1:0] event_i,
   output pm_state_e          state_o,
   output logic               wake_o,
   output logic               mask_o
);

   localparam int CNT_W = $clog2(MASK_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MASK_CYCLES);

   pm_state_e            state_q, state_d;
   logic [NUM_EN-1:0]    en_q;
   logic [CNT_W-1:0]     mask_q, mask_d;
   logic                 wake_d;
   logic [NUM_SRC-1:0]   pending;
   logic                 wake_cond;
   logic                 any_flag;
   logic                 want_sleep;
   logic                 want_suspend;

   assign pending   = flags_i | event_i;
   assign wake_cond = (|(pending[NUM_EN-1:0] & en_q)) | pending[SRC_RSTPIN];
   assign any_flag  = |flags_i;
   assign want_sleep   = wr_i && wdata_i[BIT_SLEEP];
   assign want_suspend = wr_i && wdata_i[BIT_SUSPEND];

   always_comb begin
      state_d = state_q;
      wake_d  = 1'b0;
      mask_d  = (mask_q != '0) ? mask_q - 1'b1 : mask_q;
      unique case (state_q)
         PM_ACTIVE: begin
            if (!any_flag) begin
               if (want_sleep)
                  state_d = PM_SLEEP;
               else if (want_suspend)
                  state_d = PM_SUSPEND;
            end
         end
         PM_SLEEP: begin
            if (wake_cond) begin
               state_d = PM_ACTIVE;
               wake_d  = 1'b1;
            end
         end
         PM_SUSPEND: begin
            if (wake_cond) begin
               state_d = PM_ACTIVE;
               wake_d  = 1'b1;
               mask_d  = CNT_LOAD;
            end
         end
         default: state_d = PM_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PM_ACTIVE;
         en_q    <= '0;
         wake_o  <= 1'b0;
         mask_q  <= '0;
      end else begin
         state_q <= state_d;
         wake_o  <= wake_d;
         mask_q  <= mask_d;
         if (wr_i)
            en_q <= wdata_i[NUM_EN-1:0];
      end
   end

   assign state_o = state_q;
   assign mask_o  = (mask_q != '0);

endmodule

// File: rtl/pmu_wake_ctrl.sv
module pmu_wake_ctrl
   import pmu_wake_pkg::*;
#(
   parameter logic [4:0] RST_FLAGS   = 5'b00000,
   parameter int         SYNC_STAGES = 2,
   parameter int         MASK_CYCLES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       rst_pin_i,
   input  logic       osc_fail_i,
   input  logic       alarm_i,
   input  logic       port_match_i,
   input  logic       cmp_i,
   output logic       sleep_req_o,
   output logic       suspend_req_o,
   output logic       wake_o
);

   localparam int PAD_W = REG_W - NUM_SRC;

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MASK_CYCLES < 1) begin : g_chk_mask
         $error("MASK_CYCLES must be at least 1");
      end
      if (PAD_W != 3) begin : g_chk_layout
         $error("register layout needs three command bits above the flags");
      end
   endgenerate

   logic [NUM_SRC-1:0] events;
   logic [NUM_SRC-1:0] flags;
   logic               cmp_rise;
   logic               pin_fall;
   logic               clr;
   logic               mask_act;
   pm_state_e          state;

   pmu_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0), .IDLE(1'b0)) u_cmp_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (cmp_i),
      .edge_o  (cmp_rise)
   );

   pmu_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b1), .IDLE(1'b1)) u_pin_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (rst_pin_i),
      .edge_o  (pin_fall)
   );

   always_comb begin
      events              = '0;
      events[SRC_RSTPIN]  = pin_fall;
      events[SRC_OSCFAIL] = osc_fail_i;
      events[SRC_ALARM]   = alarm_i;
      events[SRC_PMATCH]  = port_match_i;
      events[SRC_CMP]     = cmp_rise;
   end

   assign clr = reg_wr && reg_wdata[BIT_CLEAR];

   pmu_wake_flags #(.NSRC(NUM_SRC), .RST_FLAGS(RST_FLAGS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clr),
      .event_i (events),
      .flags_o (flags)
   );

   pmu_mode_ctrl #(.MASK_CYCLES(MASK_CYCLES)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr),
      .wdata_i (reg_wdata),
      .flags_i (flags),
      .event_i (events),
      .state_o (state),
      .wake_o  (wake_o),
      .mask_o  (mask_act)
   );

   assign sleep_req_o   = (state == PM_SLEEP);
   assign suspend_req_o = (state == PM_SUSPEND);
   assign reg_rdata     = {{PAD_W{1'b0}}, (mask_act ? {NUM_SRC{1'b0}} : flags)};

endmodule

// File: rtl/pmu_wake_ctrl_chk.sv
module pmu_wake_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic [7:0] reg_wdata,
   input logic [7:0] reg_rdata,
   input logic       sleep_req_o,
   input logic       suspend_req_o,
   input logic       wake_o
);

   p_cmd_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[7:5] == 3'b000);

   p_one_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(sleep_req_o && suspend_req_o));

   p_blocked_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_wdata[7] || reg_wdata[6]) && (reg_rdata[4:0] != 5'd0)
       && !sleep_req_o && !suspend_req_o) |=> !sleep_req_o && !suspend_req_o);

   p_wake_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |=> !wake_o);

   p_wake_from_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> $past(sleep_req_o || suspend_req_o) && !sleep_req_o && !suspend_req_o);

   p_mask_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(suspend_req_o) |-> reg_rdata[4:0] == 5'd0);

   p_mask_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(suspend_req_o) |=> reg_rdata[4:0] == 5'd0);

endmodule

bind pmu_wake_ctrl pmu_wake_ctrl_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_wr        (reg_wr),
   .reg_wdata     (reg_wdata),
   .reg_rdata     (reg_rdata),
   .sleep_req_o   (sleep_req_o),
   .suspend_req_o (suspend_req_o),
   .wake_o        (wake_o)
);

// File: tb/tb_pmu_wake_ctrl.sv
module tb_pmu_wake_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       rst_pin = 1'b1;
   logic       osc_fail = 1'b0;
   logic       alarm = 1'b0;
   logic       pmatch = 1'b0;
   logic       cmp = 1'b0;
   logic       sleep_req, suspend_req, wake;

   logic       p_wr = 1'b0;
   logic [7:0] p_wdata = 8'h00;
   logic [7:0] p_rdata;
   logic       p_sleep, p_suspend, p_wake;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmu_wake_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .rst_pin_i(rst_pin), .osc_fail_i(osc_fail),
      .alarm_i(alarm), .port_match_i(pmatch), .cmp_i(cmp),
      .sleep_req_o(sleep_req), .suspend_req_o(suspend_req), .wake_o(wake)
   );

   pmu_wake_ctrl #(.RST_FLAGS(5'b10010)) dut_preset (
      .clk(clk), .rst_n(rst_n), .reg_wr(p_wr), .reg_wdata(p_wdata),
      .reg_rdata(p_rdata), .rst_pin_i(1'b1), .osc_fail_i(1'b0),
      .alarm_i(1'b0), .port_match_i(1'b0), .cmp_i(1'b0),
      .sleep_req_o(p_sleep), .suspend_req_o(p_suspend), .wake_o(p_wake)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int m_flags, m_en, m_mode, m_wake, m_mask;
   bit cq[$];
   bit rq[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flags = 0; m_en = 0; m_mode = 0; m_wake = 0; m_mask = 0;
         cq = '{0, 0, 0};
         rq = '{1, 1, 1};
      end else begin
         int ev, nf, src, nmode, nmask, nwake;
         bit wk;
         ev = 0;
         if (cq[1] && !cq[2]) ev |= 1;
         if (pmatch)          ev |= 2;
         if (alarm)           ev |= 4;
         if (osc_fail)        ev |= 8;
         if (!rq[1] && rq[2]) ev |= 16;
         nf = m_flags;
         if (reg_wr && reg_wdata[5]) nf = 0;
         nf |= ev;
         src = m_flags | ev;
         wk = ((src & m_en & 15) != 0) || ((src & 16) != 0);
         nmode = m_mode;
         nwake = 0;
         nmask = (m_mask > 0) ? m_mask - 1 : 0;
         if (m_mode == 0) begin
            if (reg_wr && m_flags == 0) begin
               if (reg_wdata[7]) nmode = 1;
               else if (reg_wdata[6]) nmode = 2;
            end
         end else if (wk) begin
            nmode = 0;
            nwake = 1;
            if (m_mode == 2) nmask = 2;
         end
         if (reg_wr) m_en = reg_wdata & 15;
         m_flags = nf; m_mode = nmode; m_wake = nwake; m_mask = nmask;
         cq.push_front(cmp); void'(cq.pop_back());
         rq.push_front(rst_pin); void'(rq.pop_back());
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R1 R4 rdata vs model", reg_rdata, (m_mask > 0) ? 0 : m_flags);
         check("R2 sleep vs model", sleep_req, m_mode == 1);
         check("R2 suspend vs model", suspend_req, m_mode == 2);
         check("R7 wake vs model", wake, m_wake);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic write_reg(input logic [7:0] b);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = b;
      @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'h00;
   endtask

   task automatic write_preset(input logic [7:0] b);
      @(negedge clk); p_wr = 1'b1; p_wdata = b;
      @(negedge clk); p_wr = 1'b0; p_wdata = 8'h00;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         1: pmatch = 1'b1;
         2: alarm = 1'b1;
         default: osc_fail = 1'b1;
      endcase
      @(negedge clk);
      pmatch = 1'b0; alarm = 1'b0; osc_fail = 1'b0;
   endtask

   task automatic pin_fall();
      @(negedge clk); rst_pin = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state of both builds
      check("R11 rdata after reset", reg_rdata, 8'h00);
      check("R11 no request after reset", {sleep_req, suspend_req, wake}, 0);
      check("R11 preset flags", p_rdata, 8'h12);

      // preset build: entry blocked until flags are cleared
      write_preset(8'h80);
      check("R5 preset sleep blocked", p_sleep, 0);
      write_preset(8'h20);
      check("R3 preset clear", p_rdata, 8'h00);
      write_preset(8'h80);
      check("R2 preset sleep after clear", p_sleep, 1);

      // R4 event latches regardless of enable, R5 blocks entry
      pulse(2);
      check("R4 alarm flag bit2", reg_rdata, 8'h04);
      write_reg(8'h80);
      check("R5 sleep blocked by flag", sleep_req, 0);
      write_reg(8'h40);
      check("R5 suspend blocked by flag", suspend_req, 0);
      write_reg(8'h20);
      check("R3 clear all flags", reg_rdata, 8'h00);

      // R10 event coincident with clear survives
      @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h20; pmatch = 1'b1;
      @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'h00; pmatch = 1'b0;
      check("R10 port-match survives clear", reg_rdata, 8'h02);
      write_reg(8'h20);

      // R9 comparator sync latency and edge direction
      @(negedge clk); cmp = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R9 cmp flag not yet set", reg_rdata, 8'h00);
      @(negedge clk);
      check("R9 cmp flag after third edge", reg_rdata, 8'h01);
      write_reg(8'h20);
      @(negedge clk); cmp = 1'b0;
      idle(4);
      check("R9 cmp falling sets nothing", reg_rdata, 8'h00);
      pin_fall();
      check("R9 reset-pin fall flag bit4", reg_rdata, 8'h10);
      rst_pin = 1'b1;
      idle(4);
      write_reg(8'h20);
      check("R9 reset-pin rise sets nothing", reg_rdata, 8'h00);

      // R7 sleep: disabled source does not wake, enabled one does
      write_reg(8'h84);
      check("R2 sleep entered", sleep_req, 1);
      pulse(1);
      check("R7 disabled source keeps sleep", sleep_req, 1);
      check("R4 disabled source flag latched", reg_rdata, 8'h02);
      pulse(2);
      check("R7 enabled alarm wakes", {sleep_req, wake}, 2'b01);
      check("R8 flags visible right after sleep wake", reg_rdata, 8'h06);
      @(negedge clk);
      check("R7 wake is single cycle", wake, 0);
      write_reg(8'h20);

      // R6 enables replaced by the mode-request byte
      write_reg(8'h02);
      write_reg(8'h80);
      check("R6 sleep with empty enable byte", sleep_req, 1);
      pulse(1);
      check("R6 earlier enable dropped", sleep_req, 1);
      pin_fall();
      check("R7 reset-pin fall wakes", {sleep_req, wake}, 2'b01);
      rst_pin = 1'b1;
      idle(4);
      write_reg(8'h20);

      // R2 both mode bits: sleep wins
      write_reg(8'hC1);
      check("R2 both bits give sleep", {sleep_req, suspend_req}, 2'b10);
      pulse(3);
      check("R7 disabled osc-fail keeps sleep", sleep_req, 1);
      pin_fall();
      rst_pin = 1'b1;
      idle(4);
      write_reg(8'h20);

      // R8 suspend wake masks flags for two clocks
      write_reg(8'h48);
      check("R2 suspend entered", suspend_req, 1);
      pulse(3);
      check("R7 osc-fail wakes suspend", {suspend_req, wake}, 2'b01);
      check("R8 masked first clock", reg_rdata, 8'h00);
      @(negedge clk);
      check("R8 masked second clock", reg_rdata, 8'h00);
      @(negedge clk);
      check("R8 flags visible after mask", reg_rdata, 8'h08);
      write_reg(8'h20);
      idle(3);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule